// File: doc/BRIEF.md
# Radix Page Table Walker

This block translates a 64-bit effective address into a real address by walking a radix tree kept in memory. When `start` is accepted, it captures the effective address, the process identifier, the process-table pointer and three access qualifiers: privileged, store and instruction fetch. It first reads the process-table entry for the process. That entry gives the tree size, the root directory size and the root directory base.

After reading that entry, the block checks that the address fits the tree. It then descends through directory levels. Each level issues one 8-byte read on a request/valid memory port. Entries are used exactly as returned, with no byte reordering.

A walk ends on a leaf entry, or earlier on a fault. The leaf is checked for access permission and for the reference and change bits. At the end of the walk the block pulses `done` for one cycle. With that pulse it gives either the real address or exactly one error flag. All bit numbers below count from the least significant bit, bit 0.

Top module: `radix_walker`

## Requirements
- R1: The process-table read address is built from high to low as follows: eight zero bits, then pointer bits 55:36, then ((pointer bits 35:12 AND NOT m) OR (effective-PID bits 31:8 AND m)), then effective-PID bits 7:0, then four zero bits. Here m is a 24-bit mask whose number of low ones equals pointer bits 4:0.
- R2: The effective PID is zero when effective-address bit 63 is 1. Otherwise it is the `pid` input.
- R3: The process-table entry supplies three values. The tree size is the 6-bit value {0, bits 62:61, bits 7:5}. The root level size is bits 4:0. The directory base is bits 55:8 followed by eight zero bits. A root level size of 0 ends the walk with `err_inval`.
- R4: `err_seg` ends the walk in two cases: address bit 63 differs from bit 62, or any of address bits 61:31 is set above the low tree-size bits.
- R5: A root level size below 5, above 16, or above tree size + 19 ends the walk with `err_tree`. Otherwise the remaining shift becomes tree size + 19 − level size.
- R6: Each directory read address is built as eight zero bits, then base bits 55:19, then ((base bits 18:3 AND NOT k) OR (idx AND k)), then three zero bits. Here k has as many low ones as the current level size, and idx is the low 16 bits of address bits 61:12 shifted right by the remaining shift.
- R7: In a directory entry, bit 63 is valid and bit 62 is leaf. A directory entry with bit 63 clear ends the walk with `err_inval`.
- R8: A valid non-leaf entry gives a new level size in bits 4:0. If that size is below 5, above 16, or above the remaining shift, the walk ends with `err_tree`. Otherwise the shift drops by that size, the base becomes entry bits 55:8 followed by eight zero bits, and the next level is read.
- R9: A leaf permits access only when the request is privileged or leaf bit 3 is 0. For a data access, permission is bit 1 OR (bit 2 AND NOT store). For an instruction fetch, permission is bit 0 AND NOT bit 5. A refused access raises `err_perm`.
- R10: The reference/change check passes when bit 8 AND (bit 7 OR NOT store). It raises `err_rc` only when permission passed. A permission failure reports `err_perm` alone.
- R11: The real address is built as eight zero bits, then ((leaf bits 55:12 AND NOT p) OR (address bits 55:12 AND p)), then address bits 11:0. Here p has as many low ones as the remaining shift at the leaf.
- R12: In the cycle after reset, `busy`, `done`, `mem_req` and every error flag are 0. `start` is ignored while `busy` is 1. `mem_req` lasts one cycle per read. `done` is a one-cycle pulse, and at most one error flag is set with it. Error flags are 0 outside `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| ea | input | 64 | Effective address |
| pid | input | 32 | Process identifier |
| ptab | input | 64 | Process-table pointer: base in bits 55:12, size in bits 4:0 |
| priv | input | 1 | Privileged access |
| store | input | 1 | Access is a store |
| ifetch | input | 1 | Access is an instruction fetch |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 64 | Read address, valid with mem_req |
| mem_vld | input | 1 | Read data valid |
| mem_data | input | 64 | Returned 8-byte entry |
| done | output | 1 | Walk finished (one-cycle pulse) |
| ra | output | 64 | Real address, updated on a successful walk |
| err_inval | output | 1 | Invalid entry or zero root size |
| err_seg | output | 1 | Segment error |
| err_tree | output | 1 | Bad level or tree size |
| err_perm | output | 1 | Permission refused |
| err_rc | output | 1 | Reference/change check failed |

## Verification
The walker has no parameters, because the entry format fixes every width. The bench therefore builds a single four-level tree: tree size 21, root size 13, then three levels of 9. It lays the tables out from the requested address, so a wrongly formed read address returns an empty entry and shows up as a fault. Leaves placed at the second and third levels bring large-page masking within reach. Pointer size fields of 0, 3 and 8, combined with several PIDs, exercise the PID merge. A full sweep of the 1024 combinations of the three access qualifiers and the seven leaf bits that matter covers every permission and reference/change outcome, including their priority.

// File: rtl/radix_walker.sv
module radix_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [63:0] ea,
  input  logic [31:0] pid,
  input  logic [63:0] ptab,
  input  logic        priv,
  input  logic        store,
  input  logic        ifetch,
  output logic        busy,
  output logic        mem_req,
  output logic [63:0] mem_addr,
  input  logic        mem_vld,
  input  logic [63:0] mem_data,
  output logic        done,
  output logic [63:0] ra,
  output logic        err_inval,
  output logic        err_seg,
  output logic        err_tree,
  output logic        err_perm,
  output logic        err_rc
);
  typedef enum logic [2:0] {S_IDLE, S_PREQ, S_PWAIT, S_SEG, S_DREQ, S_DWAIT} st_t;

  st_t         st;
  logic [63:0] ea_q, ptab_q;
  logic [31:0] epid_q;
  logic        priv_q, store_q, ifetch_q;
  logic [6:0]  shift_q;
  logic [4:0]  lvl_q;
  logic [55:0] base_q;

  function automatic logic [63:0] ones(input logic [6:0] n);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[i] = (i < int'(n));
    return r;
  endfunction

  logic [63:0] pmask, lmask, smask;
  logic [63:0] prt_addr, dir_addr, ra_calc;
  logic [49:0] eash;
  logic [15:0] idx;
  logic [6:0]  limit;
  logic        seg_bad, root_bad, nls_bad, perm_ok, rc_ok;
  logic [4:0]  nls;

  assign pmask = ones({2'b0, ptab_q[4:0]});
  assign lmask = ones({2'b0, lvl_q});
  assign smask = ones(shift_q);

  assign prt_addr = {8'h0, ptab_q[55:36],
                     (ptab_q[35:12] & ~pmask[23:0]) | (epid_q[31:8] & pmask[23:0]),
                     epid_q[7:0], 4'h0};

  assign eash     = ea_q[61:12] >> shift_q;
  assign idx      = eash[15:0];
  assign dir_addr = {8'h0, base_q[55:19],
                     (base_q[18:3] & ~lmask[15:0]) | (idx & lmask[15:0]), 3'b000};

  assign limit    = shift_q + 7'd19;
  assign seg_bad  = (ea_q[63] ^ ea_q[62]) | (|(ea_q[61:31] & ~smask[30:0]));
  assign root_bad = (lvl_q < 5'd5) | (lvl_q > 5'd16) | ({2'b0, lvl_q} > limit);

  assign nls      = mem_data[4:0];
  assign nls_bad  = (nls < 5'd5) | (nls > 5'd16) | ({2'b0, nls} > shift_q);

  assign perm_ok  = (priv_q | ~mem_data[3]) &
                    (ifetch_q ? (mem_data[0] & ~mem_data[5])
                              : (mem_data[1] | (mem_data[2] & ~store_q)));
  assign rc_ok    = mem_data[8] & (mem_data[7] | ~store_q);
  assign ra_calc  = {8'h0, (mem_data[55:12] & ~smask[43:0]) | (ea_q[55:12] & smask[43:0]),
                     ea_q[11:0]};

  assign busy     = (st != S_IDLE);
  assign mem_req  = (st == S_PREQ) || (st == S_DREQ);
  assign mem_addr = (st == S_PREQ) ? prt_addr : dir_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      ea_q <= '0; ptab_q <= '0; epid_q <= '0;
      priv_q <= 1'b0; store_q <= 1'b0; ifetch_q <= 1'b0;
      shift_q <= '0; lvl_q <= '0; base_q <= '0;
      done <= 1'b0; ra <= '0;
      err_inval <= 1'b0; err_seg <= 1'b0; err_tree <= 1'b0;
      err_perm <= 1'b0; err_rc <= 1'b0;
    end else begin
      done <= 1'b0;
      err_inval <= 1'b0; err_seg <= 1'b0; err_tree <= 1'b0;
      err_perm <= 1'b0; err_rc <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          ea_q     <= ea;
          epid_q   <= ea[63] ? 32'h0 : pid;
          ptab_q   <= ptab;
          priv_q   <= priv;
          store_q  <= store;
          ifetch_q <= ifetch;
          st       <= S_PREQ;
        end
        S_PREQ: st <= S_PWAIT;
        S_PWAIT: if (mem_vld) begin
          if (mem_data[4:0] == 5'd0) begin
            err_inval <= 1'b1; done <= 1'b1; st <= S_IDLE;
          end else begin
            shift_q <= {2'b0, mem_data[62:61], mem_data[7:5]};
            lvl_q   <= mem_data[4:0];
            base_q  <= {mem_data[55:8], 8'h0};
            st      <= S_SEG;
          end
        end
        S_SEG: begin
          if (seg_bad) begin
            err_seg <= 1'b1; done <= 1'b1; st <= S_IDLE;
          end else if (root_bad) begin
            err_tree <= 1'b1; done <= 1'b1; st <= S_IDLE;
          end else begin
            shift_q <= limit - {2'b0, lvl_q};
            st      <= S_DREQ;
          end
        end
        S_DREQ: st <= S_DWAIT;
        S_DWAIT: if (mem_vld) begin
          if (!mem_data[63]) begin
            err_inval <= 1'b1; done <= 1'b1; st <= S_IDLE;
          end else if (mem_data[62]) begin
            done <= 1'b1; st <= S_IDLE;
            if (perm_ok && rc_ok) ra <= ra_calc;
            else begin
              err_perm <= ~perm_ok;
              err_rc   <= perm_ok;
            end
          end else if (nls_bad) begin
            err_tree <= 1'b1; done <= 1'b1; st <= S_IDLE;
          end else begin
            shift_q <= shift_q - {2'b0, nls};
            lvl_q   <= nls;
            base_q  <= {mem_data[55:8], 8'h0};
            st      <= S_DREQ;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/radix_walker_chk.sv
module radix_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        mem_req,
  input logic [63:0] mem_addr,
  input logic        done,
  input logic        err_inval,
  input logic        err_seg,
  input logic        err_tree,
  input logic        err_perm,
  input logic        err_rc,
  input logic [63:0] ea_q
);
  logic [4:0] errs;
  assign errs = {err_inval, err_seg, err_tree, err_perm, err_rc};

  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r12_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones(errs) <= 1));
  a_r12_flags_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (errs == 5'b0));
  a_r10_perm_first: assert property (@(posedge clk) disable iff (!rst_n)
    err_rc |-> !err_perm);
  a_r12_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  a_r12_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);
  a_r12_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(ea_q)));
  a_r12_start_begins: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  a_r6_addr_shape: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[2:0] == 3'b0 && mem_addr[63:56] == 8'h0));
endmodule

bind radix_walker radix_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .mem_req(mem_req),
  .mem_addr(mem_addr), .done(done), .err_inval(err_inval), .err_seg(err_seg),
  .err_tree(err_tree), .err_perm(err_perm), .err_rc(err_rc), .ea_q(ea_q)
);

// File: tb/radix_walker_test.sv
module radix_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] ea = '0;
  logic [31:0] pid = '0;
  logic [63:0] ptab = '0;
  logic        priv = 1'b0, store = 1'b0, ifetch = 1'b0;
  logic        busy, mem_req, done;
  logic [63:0] mem_addr, ra;
  logic        mem_vld = 1'b0;
  logic [63:0] mem_data = '0;
  logic        err_inval, err_seg, err_tree, err_perm, err_rc;

  always #4 clk = ~clk;

  radix_walker uut (
    .clk(clk), .rst_n(rst_n), .start(start), .ea(ea), .pid(pid), .ptab(ptab),
    .priv(priv), .store(store), .ifetch(ifetch), .busy(busy), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_vld(mem_vld), .mem_data(mem_data), .done(done),
    .ra(ra), .err_inval(err_inval), .err_seg(err_seg), .err_tree(err_tree),
    .err_perm(err_perm), .err_rc(err_rc)
  );

  localparam logic [63:0] E0   = 64'h4000_0000_0002_00AD;
  localparam logic [63:0] E1   = 64'h8000_0000_0004_0009;
  localparam logic [63:0] E2   = 64'h8000_0000_0006_0009;
  localparam logic [63:0] E3   = 64'h8000_0000_0008_0009;
  localparam logic [63:0] LEAF = 64'hC000_0000_0500_1183;
  localparam logic [4:0] X_OK = 5'b00000, X_INV = 5'b10000, X_SEG = 5'b01000,
                         X_TREE = 5'b00100, X_PERM = 5'b00010, X_RC = 5'b00001;

  logic [63:0] ta [5];
  logic [63:0] td [5];
  logic [63:0] req_log [16];
  int          req_n = 0;
  int          done_cnt = 0;
  int          n_cmp = 0, n_bad = 0;
  logic [63:0] g_ra;
  logic [4:0]  g_err;
  logic [63:0] g_ptab;

  function automatic logic [63:0] lookup(input logic [63:0] a);
    for (int k = 0; k < 5; k++) if (ta[k] == a) return td[k];
    return 64'h0;
  endfunction

  initial begin
    int cnt;
    logic [63:0] pa;
    cnt = 0; pa = '0;
    forever begin
      @(negedge clk);
      mem_vld = 1'b0;
      if (cnt == 1) begin mem_vld = 1'b1; mem_data = lookup(pa); end
      if (cnt > 0) cnt--;
      if (mem_req) begin
        pa = mem_addr; cnt = 2;
        if (req_n < 16) req_log[req_n] = mem_addr;
        req_n++;
      end
      if (done) done_cnt++;
    end
  end

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic build(input logic [63:0] a, input logic [31:0] p, input logic [4:0] s);
    logic [31:0] ep;
    ep = a[63] ? 32'h0 : p;
    g_ptab = 64'h0100_0000 | {59'b0, s};
    ta[0] = 64'h0100_0000 | (((({32'b0, ep}) >> 8) & ((64'd1 << s) - 1)) << 12)
          | ({56'b0, ep[7:0]} << 4);
    td[0] = E0;
    ta[1] = 64'h2_0000 + 8 * {51'b0, a[51:39]}; td[1] = E1;
    ta[2] = 64'h4_0000 + 8 * {55'b0, a[38:30]}; td[2] = E2;
    ta[3] = 64'h6_0000 + 8 * {55'b0, a[29:21]}; td[3] = E3;
    ta[4] = 64'h8_0000 + 8 * {55'b0, a[20:12]}; td[4] = LEAF;
  endtask

  task automatic walk(input logic [63:0] a, input logic [31:0] p,
                      input logic pr, input logic st, input logic fe);
    bit got;
    req_n = 0;
    @(negedge clk);
    start = 1'b1; ea = a; pid = p; ptab = g_ptab; priv = pr; store = st; ifetch = fe;
    @(negedge clk);
    start = 1'b0;
    got = 0;
    for (int t = 0; t < 400 && !got; t++) begin
      if (done) begin
        got = 1;
        g_ra = ra;
        g_err = {err_inval, err_seg, err_tree, err_perm, err_rc};
      end else @(negedge clk);
    end
    if (!got) begin
      n_cmp++; n_bad++;
      $display("FAIL R12: walk timeout got 0 expected 1");
      g_err = 5'b11111; g_ra = '0;
    end
  endtask

  task automatic full_ok(input string tag, input logic [63:0] a, input logic [31:0] p,
                         input logic [4:0] s);
    build(a, p, s);
    walk(a, p, 1'b1, 1'b1, 1'b0);
    chk({tag, " errs"}, {59'b0, g_err}, {59'b0, X_OK});
    chk({tag, " ra"}, g_ra, 64'h0500_1000 | {52'b0, a[11:0]});
    chk({tag, " reads"}, 64'(req_n), 64'd5);
    for (int k = 0; k < 5; k++) chk({tag, " read addr"}, req_log[k], ta[k]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R12: watchdog expired got running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] a;
    logic [9:0]  v;
    logic        pok, rok;
    logic [4:0]  xe;
    int          dc;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 reset state", {56'b0, busy, done, mem_req, err_inval, err_seg, err_tree,
        err_perm, err_rc}, 64'h0);

    full_ok("R6 R11 ea 1101", 64'h1101, 32'h0, 5'd0);
    full_ok("R6 R11 high index bits", 64'h000F_FFFF_FFFF_F123, 32'h0, 5'd0);
    full_ok("R4 R6 bit 51 inside tree", 64'h0008_0000_0000_0ABC, 32'h0, 5'd0);
    for (int k = 0; k < 64; k++) begin
      a = ({58'b0, 6'(k)} << 12) | ({58'b0, 6'(k ^ 6'h15)} << 21)
        | ({58'b0, 6'(k + 3)} << 30) | ({58'b0, 6'(63 - k)} << 39) | 64'(k * 37);
      full_ok("R6 R11 index sweep", a, 32'h0, 5'd0);
    end

    for (int s = 0; s < 3; s++)
      for (int q = 0; q < 4; q++)
        for (int h = 0; h < 2; h++) begin
          logic [31:0] pp;
          pp = (q == 0) ? 32'h0 : (q == 1) ? 32'h1234_5678 : (q == 2) ? 32'hFFFF_FFFF
                                                                      : 32'h0000_0A5C;
          a = h ? 64'hC000_0000_0000_1101 : 64'h1101;
          full_ok(h ? "R1 R2 pid forced zero" : "R1 pid merge", a, pp,
                  (s == 0) ? 5'd0 : (s == 1) ? 5'd3 : 5'd8);
        end

    a = 64'h1234_5678;
    build(a, 0, 0); td[2] = 64'hC000_0001_4000_3183;
    walk(a, 0, 1, 1, 0);
    chk("R11 leaf at level two errs", {59'b0, g_err}, 64'h0);
    chk("R11 leaf at level two ra", g_ra, 64'h1_4000_0000 | (a & 64'h3FFF_FFFF));
    chk("R11 leaf at level two reads", 64'(req_n), 64'd3);
    a = 64'h0000_0000_001A_BCDE;
    build(a, 0, 0); td[3] = 64'hC000_0000_0A00_1183;
    walk(a, 0, 1, 1, 0);
    chk("R11 leaf at level three ra", g_ra, 64'h0A00_0000 | (a & 64'h1F_FFFF));

    a = 64'h8000_0000_0000_1000;
    build(a, 0, 0); walk(a, 0, 1, 0, 0);
    chk("R4 top bits differ", {59'b0, g_err}, {59'b0, X_SEG});
    chk("R4 only one read", 64'(req_n), 64'd1);
    a = 64'h4000_0000_0000_1000;
    build(a, 0, 0); walk(a, 0, 1, 0, 0);
    chk("R4 top bits differ other way", {59'b0, g_err}, {59'b0, X_SEG});
    a = 64'h0010_0000_0000_1000;
    build(a, 0, 0); walk(a, 0, 1, 0, 0);
    chk("R4 bit 52 outside tree", {59'b0, g_err}, {59'b0, X_SEG});

    a = 64'h1101;
    build(a, 0, 0); td[0] = (E0 & ~64'h1F) | 64'd4; walk(a, 0, 1, 0, 0);
    chk("R5 root size 4", {59'b0, g_err}, {59'b0, X_TREE});
    build(a, 0, 0); td[0] = (E0 & ~64'h1F) | 64'd17; walk(a, 0, 1, 0, 0);
    chk("R5 root size 17", {59'b0, g_err}, {59'b0, X_TREE});
    build(a, 0, 0); td[0] = E0 & ~64'h1F; walk(a, 0, 1, 0, 0);
    chk("R3 root size zero", {59'b0, g_err}, {59'b0, X_INV});
    build(a, 0, 0); ta[0] = 64'hFFF0; walk(a, 0, 1, 0, 0);
    chk("R3 empty process entry", {59'b0, g_err}, {59'b0, X_INV});

    build(a, 0, 0); td[2] = E2 & ~(64'd1 << 63); walk(a, 0, 1, 0, 0);
    chk("R7 invalid directory entry", {59'b0, g_err}, {59'b0, X_INV});
    chk("R7 stops after third read", 64'(req_n), 64'd3);
    build(a, 0, 0); td[1] = (E1 & ~64'h1F) | 64'd4; walk(a, 0, 1, 0, 0);
    chk("R8 level size 4", {59'b0, g_err}, {59'b0, X_TREE});
    build(a, 0, 0); td[1] = (E1 & ~64'h1F) | 64'd17; walk(a, 0, 1, 0, 0);
    chk("R8 level size 17", {59'b0, g_err}, {59'b0, X_TREE});
    build(a, 0, 0); td[3] = (E3 & ~64'h1F) | 64'd10; walk(a, 0, 1, 0, 0);
    chk("R8 level size above shift", {59'b0, g_err}, {59'b0, X_TREE});
    build(a, 0, 0); td[3] = 64'h8000_0000_000A_0009; ta[4] = 64'hA_0000 + 8; walk(a, 0, 1, 1, 0);
    chk("R8 new base followed", g_ra, 64'h0500_1101);

    for (int k = 0; k < 1024; k++) begin
      v = 10'(k);
      build(a, 0, 0);
      td[4] = 64'hC000_0000_0500_1000 | {63'b0, v[3]} | ({63'b0, v[4]} << 1)
            | ({63'b0, v[5]} << 2) | ({63'b0, v[6]} << 3) | ({63'b0, v[7]} << 5)
            | ({63'b0, v[8]} << 7) | ({63'b0, v[9]} << 8);
      walk(a, 0, v[0], v[1], v[2]);
      pok = (v[0] | ~v[6]) & (v[2] ? (v[3] & ~v[7]) : (v[4] | (v[5] & ~v[1])));
      rok = v[9] & (v[8] | ~v[1]);
      xe = !pok ? X_PERM : !rok ? X_RC : X_OK;
      chk("R9 R10 leaf check", {59'b0, g_err}, {59'b0, xe});
      if (xe == X_OK) chk("R9 R11 granted address", g_ra, 64'h0500_1101);
    end

    build(64'h1101, 0, 0);
    dc = done_cnt;
    req_n = 0;
    @(negedge clk);
    start = 1'b1; ea = 64'h1101; pid = 0; ptab = g_ptab; priv = 1; store = 1; ifetch = 0;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    start = 1'b1; ea = 64'h8000_0000_0000_2202;
    @(negedge clk); start = 1'b0;
    for (int t = 0; t < 400 && !done; t++) @(negedge clk);
    chk("R12 start ignored while busy ra", ra, 64'h0500_1101);
    chk("R12 no error on done", {59'b0, err_inval, err_seg, err_tree, err_perm, err_rc}, 64'h0);
    @(negedge clk);
    chk("R12 done lasts one cycle", {63'b0, done}, 64'h0);
    repeat (60) @(negedge clk);
    chk("R12 single completion", 64'(done_cnt - dc), 64'd1);
    chk("R12 reads of one walk", 64'(req_n), 64'd5);
    chk("R12 idle after walk", {63'b0, busy}, 64'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule